// File: doc/BRIEF.md
# Memory Partition Request Router

This block moves memory requests through one partition of a memory system. It sits between the on-chip network and a DRAM controller. An accepted request first waits in a fixed-latency delay line. It then enters a bounded ingress queue. From there, requests flagged as texture are looked up in an external cache. All other requests go straight to a bounded DRAM request queue.

Responses from DRAM pass through a bounded return queue. A texture response is handed to the external cache as a fill. Any other response goes into the bounded reply queue toward the network. The external cache sends back fill-completed replies, and these also enter the reply queue. Every port uses a valid/ready handshake, with at most one transfer per port per clock.

A request carries an address, a texture flag and a tag. The block keeps a count of requests it has accepted but not yet delivered. It reports itself busy while that count is non-zero.

Top module: `mpart_router`

## Requirements
- R1: `in_ready` is high exactly when the delay line holds fewer than `D_DLY` requests and fewer than `MAX_OUT` requests are outstanding. A transfer happens when `in_valid` and `in_ready` are both high at a rising edge.
- R2: A request accepted at edge e enters the ingress queue at edge e+`DELAY` at the earliest, and requests leave the delay line in arrival order. On an otherwise idle path, a non-texture request shows on `dreq_valid` `DELAY`+2 cycles after the cycle in which it was accepted.
- R3: `part_full` is high exactly when the ingress queue holds `D_I2C` entries. While it is high, no request leaves the delay line.
- R4: `cdone_ready` is high whenever the reply queue is not full. An accepted fill-completed reply enters the reply queue with its texture flag set to 1, ahead of every other source of replies in that cycle.
- R5: A texture request at the head of the return queue drives `fill_valid` and is removed in the same cycle, with no condition. A non-texture head moves to the reply queue only if that queue is not full and no fill-completed reply is accepted in the same cycle; otherwise it stays.
- R6: The ingress head is acted on only while the DRAM request queue is not full.
- R7: A texture ingress head drives `lk_valid` only if the reply queue is not full and no other reply enters it in that cycle. The `lk_status` encoding is: 0 = hit, 1 = miss accepted, 2 or 3 = reservation failure. On a hit, the request moves into the reply queue. On a miss, it is removed. On a reservation failure, it stays at the head for the next cycle.
- R8: A non-texture ingress head moves into the DRAM request queue.
- R9: `dreq_valid` is high while the DRAM request queue is non-empty, and its head is removed when `dreq_ready` is high. `drsp_ready` is high while the return queue is not full.
- R10: `busy` is high exactly while the count of accepted requests exceeds the count of requests taken at the output. Once all traffic has drained, `busy` is low.
- R11: `out_valid` is high while the reply queue is non-empty. The queue presents its entries in the order they entered, with address, tag and texture flag unchanged.
- R12: After reset, every queue is empty, `busy` and all valid outputs are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request offered by the network |
| in_ready | output | 1 | Request can be accepted |
| in_addr | input | ADDR_W | Request address |
| in_tex | input | 1 | Request is a texture access |
| in_tag | input | TAG_W | Request tag |
| part_full | output | 1 | Ingress queue is full |
| lk_valid | output | 1 | Cache lookup presented this cycle |
| lk_addr | output | ADDR_W | Lookup address |
| lk_tag | output | TAG_W | Lookup tag |
| lk_status | input | 2 | Same-cycle lookup result: 0 hit, 1 miss, 2 or 3 reservation failure |
| fill_valid | output | 1 | Fill of a texture response into the cache |
| fill_addr | output | ADDR_W | Fill address |
| fill_tag | output | TAG_W | Fill tag |
| cdone_valid | input | 1 | Cache offers a fill-completed reply |
| cdone_ready | output | 1 | Reply queue can take it |
| cdone_addr | input | ADDR_W | Reply address |
| cdone_tag | input | TAG_W | Reply tag |
| dreq_valid | output | 1 | Request to DRAM |
| dreq_ready | input | 1 | DRAM is not full |
| dreq_addr | output | ADDR_W | DRAM request address |
| dreq_tex | output | 1 | DRAM request texture flag |
| dreq_tag | output | TAG_W | DRAM request tag |
| drsp_valid | input | 1 | DRAM response offered |
| drsp_ready | output | 1 | Return queue has room |
| drsp_addr | input | ADDR_W | Response address |
| drsp_tex | input | 1 | Response texture flag |
| drsp_tag | input | TAG_W | Response tag |
| out_valid | output | 1 | Reply to the network |
| out_ready | input | 1 | Network takes the reply |
| out_addr | output | ADDR_W | Reply address |
| out_tex | output | 1 | Reply texture flag |
| out_tag | output | TAG_W | Reply tag |
| busy | output | 1 | Requests are outstanding |

## Verification
The bench builds the block with `DELAY` of 6 and a four-entry delay line. The queues are small: two ingress entries, three DRAM request entries, two return entries and four reply entries. The outstanding limit is 10. With these values, every full condition, the outstanding limit, and the ordering of competing reply sources occur within a few cycles of traffic. The delay still stays long enough that requests pile up behind it. A 16-bit timestamp keeps the age comparison exact across the long back-pressure phases.

// File: rtl/mpart_pkg.sv
package mpart_pkg;

   // result returned in the same cycle by the external cache lookup
   typedef enum logic [1:0] {
      LK_HIT     = 2'd0,
      LK_MISS    = 2'd1,
      LK_RSVFAIL = 2'd2
   } lk_status_e;

   function automatic int unsigned occ_width(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/mpart_fifo.sv
module mpart_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [W-1:0]                 push_data,
   input  logic                         pop,
   output logic [W-1:0]                 head,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   if (DEPTH < 1) begin : g_bad_depth
      $error("mpart_fifo: DEPTH must be at least 1");
   end

   if (DEPTH > 1 && (DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         unique case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   assign head = mem[rd_ptr];

endmodule

// File: rtl/mpart_delay.sv
module mpart_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 128,
   parameter int DELAY = 115,
   parameter int TS_W  = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         acc,
   input  logic [W-1:0] in_data,
   output logic         room,
   output logic         ripe,
   output logic [W-1:0] out_data,
   input  logic         take
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [TS_W-1:0]   now;
   logic [TS_W-1:0]   head_ts;
   logic [TS_W-1:0]   age;
   logic [CNT_W-1:0]  occ;

   if (TS_W < 2 || longint'(DELAY) >= (longint'(1) << (TS_W - 1))) begin : g_bad_ts
      $error("mpart_delay: TS_W too narrow for DELAY");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now <= '0;
      else        now <= now + 1'b1;
   end

   mpart_fifo #(.W(W + TS_W), .DEPTH(DEPTH)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (acc),
      .push_data ({now, in_data}),
      .pop       (take),
      .head      ({head_ts, out_data}),
      .count     (occ)
   );

   assign age  = now - head_ts;
   assign room = occ < CNT_W'(DEPTH);
   assign ripe = (occ != '0) && (age >= TS_W'(DELAY));

endmodule

// File: rtl/mpart_track.sv
module mpart_track #(
   parameter int MAX_OUT = 255
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic room,
   output logic busy
);
   localparam int OW = $clog2(MAX_OUT + 1);

   logic [OW-1:0] pend;

   if (MAX_OUT < 1) begin : g_bad_max
      $error("mpart_track: MAX_OUT must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else begin
         unique case ({inc, dec})
            2'b10:   pend <= pend + 1'b1;
            2'b01:   pend <= pend - 1'b1;
            default: pend <= pend;
         endcase
      end
   end

   assign room = pend < OW'(MAX_OUT);
   assign busy = pend != '0;

endmodule

// File: rtl/mpart_router.sv
module mpart_router
   import mpart_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int TAG_W   = 8,
   parameter int DELAY   = 115,
   parameter int D_DLY   = 128,
   parameter int D_I2C   = 8,
   parameter int D_C2D   = 8,
   parameter int D_D2C   = 8,
   parameter int D_C2I   = 8,
   parameter int MAX_OUT = 255,
   parameter int TS_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_tex,
   input  logic [TAG_W-1:0]  in_tag,
   output logic              part_full,
   output logic              lk_valid,
   output logic [ADDR_W-1:0] lk_addr,
   output logic [TAG_W-1:0]  lk_tag,
   input  logic [1:0]        lk_status,
   output logic              fill_valid,
   output logic [ADDR_W-1:0] fill_addr,
   output logic [TAG_W-1:0]  fill_tag,
   input  logic              cdone_valid,
   output logic              cdone_ready,
   input  logic [ADDR_W-1:0] cdone_addr,
   input  logic [TAG_W-1:0]  cdone_tag,
   output logic              dreq_valid,
   input  logic              dreq_ready,
   output logic [ADDR_W-1:0] dreq_addr,
   output logic              dreq_tex,
   output logic [TAG_W-1:0]  dreq_tag,
   input  logic              drsp_valid,
   output logic              drsp_ready,
   input  logic [ADDR_W-1:0] drsp_addr,
   input  logic              drsp_tex,
   input  logic [TAG_W-1:0]  drsp_tag,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_tex,
   output logic [TAG_W-1:0]  out_tag,
   output logic              busy
);
   localparam int REQ_W = ADDR_W + TAG_W + 1;
   localparam int TEX_B = REQ_W - 1;
   localparam int I2C_W = occ_width(D_I2C);
   localparam int C2D_W = occ_width(D_C2D);
   localparam int D2C_W = occ_width(D_D2C);
   localparam int C2I_W = occ_width(D_C2I);

   if (ADDR_W < 1 || TAG_W < 1) begin : g_bad_width
      $error("mpart_router: address and tag widths must be positive");
   end
   if (D_I2C < 1 || D_C2D < 1 || D_D2C < 1 || D_C2I < 1 || D_DLY < 1) begin : g_bad_depth
      $error("mpart_router: every queue depth must be at least 1");
   end

   // delay line to ingress queue
   logic              dly_room, dly_ripe, in_acc, i2c_push;
   logic [REQ_W-1:0]  dly_head;
   logic              out_room;

   // queue state
   logic [REQ_W-1:0]  i2c_head, c2d_head, d2c_head, c2i_head, c2i_wdata;
   logic [I2C_W-1:0]  i2c_cnt;
   logic [C2D_W-1:0]  c2d_cnt;
   logic [D2C_W-1:0]  d2c_cnt;
   logic [C2I_W-1:0]  c2i_cnt;
   logic              i2c_empty, i2c_full, c2d_empty, c2d_full;
   logic              d2c_empty, d2c_full, c2i_empty, c2i_full;

   // per-cycle moves
   logic              done_push, d2c_fwd, d2c_pop, d2c_push;
   logic              head_go, head_tex, lk_hit, lk_miss, to_c2d, i2c_pop;
   logic              c2d_pop, c2i_push, c2i_pop;

   assign in_acc   = in_valid && in_ready;
   assign in_ready = dly_room && out_room;

   mpart_delay #(.W(REQ_W), .DEPTH(D_DLY), .DELAY(DELAY), .TS_W(TS_W)) u_delay (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (in_acc),
      .in_data  ({in_tex, in_tag, in_addr}),
      .room     (dly_room),
      .ripe     (dly_ripe),
      .out_data (dly_head),
      .take     (i2c_push)
   );

   mpart_track #(.MAX_OUT(MAX_OUT)) u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (in_acc),
      .dec   (c2i_pop),
      .room  (out_room),
      .busy  (busy)
   );

   mpart_fifo #(.W(REQ_W), .DEPTH(D_I2C)) u_i2c (
      .clk(clk), .rst_n(rst_n), .push(i2c_push), .push_data(dly_head),
      .pop(i2c_pop), .head(i2c_head), .count(i2c_cnt)
   );

   mpart_fifo #(.W(REQ_W), .DEPTH(D_C2D)) u_c2d (
      .clk(clk), .rst_n(rst_n), .push(to_c2d), .push_data(i2c_head),
      .pop(c2d_pop), .head(c2d_head), .count(c2d_cnt)
   );

   mpart_fifo #(.W(REQ_W), .DEPTH(D_D2C)) u_d2c (
      .clk(clk), .rst_n(rst_n), .push(d2c_push),
      .push_data({drsp_tex, drsp_tag, drsp_addr}),
      .pop(d2c_pop), .head(d2c_head), .count(d2c_cnt)
   );

   mpart_fifo #(.W(REQ_W), .DEPTH(D_C2I)) u_c2i (
      .clk(clk), .rst_n(rst_n), .push(c2i_push), .push_data(c2i_wdata),
      .pop(c2i_pop), .head(c2i_head), .count(c2i_cnt)
   );

   assign i2c_empty = i2c_cnt == '0;
   assign i2c_full  = i2c_cnt == I2C_W'(D_I2C);
   assign c2d_empty = c2d_cnt == '0;
   assign c2d_full  = c2d_cnt == C2D_W'(D_C2D);
   assign d2c_empty = d2c_cnt == '0;
   assign d2c_full  = d2c_cnt == D2C_W'(D_D2C);
   assign c2i_empty = c2i_cnt == '0;
   assign c2i_full  = c2i_cnt == C2I_W'(D_C2I);

   // delay line release: blocked while the ingress queue is full
   assign part_full = i2c_full;
   assign i2c_push  = dly_ripe && !i2c_full;

   // reply queue sources, in falling priority: fill-completed, DRAM bypass, cache hit
   assign cdone_ready = !c2i_full;
   assign done_push   = cdone_valid && !c2i_full;

   assign fill_valid = !d2c_empty && d2c_head[TEX_B];
   assign d2c_fwd    = !d2c_empty && !d2c_head[TEX_B] && !c2i_full && !done_push;
   assign d2c_pop    = fill_valid || d2c_fwd;
   assign fill_addr  = d2c_head[ADDR_W-1:0];
   assign fill_tag   = d2c_head[ADDR_W +: TAG_W];

   // ingress head routing
   assign head_go  = !i2c_empty && !c2d_full;
   assign head_tex = i2c_head[TEX_B];
   assign lk_valid = head_go && head_tex && !c2i_full && !done_push && !d2c_fwd;
   assign lk_addr  = i2c_head[ADDR_W-1:0];
   assign lk_tag   = i2c_head[ADDR_W +: TAG_W];
   assign lk_hit   = lk_valid && (lk_status == LK_HIT);
   assign lk_miss  = lk_valid && (lk_status == LK_MISS);
   assign to_c2d   = head_go && !head_tex;
   assign i2c_pop  = to_c2d || lk_hit || lk_miss;

   assign c2i_push = done_push || d2c_fwd || lk_hit;

   always_comb begin
      if (done_push)    c2i_wdata = {1'b1, cdone_tag, cdone_addr};
      else if (d2c_fwd) c2i_wdata = d2c_head;
      else              c2i_wdata = i2c_head;
   end

   // DRAM side
   assign dreq_valid = !c2d_empty;
   assign c2d_pop    = dreq_valid && dreq_ready;
   assign dreq_addr  = c2d_head[ADDR_W-1:0];
   assign dreq_tag   = c2d_head[ADDR_W +: TAG_W];
   assign dreq_tex   = c2d_head[TEX_B];
   assign drsp_ready = !d2c_full;
   assign d2c_push   = drsp_valid && drsp_ready;

   // network side
   assign out_valid = !c2i_empty;
   assign c2i_pop   = out_valid && out_ready;
   assign out_addr  = c2i_head[ADDR_W-1:0];
   assign out_tag   = c2i_head[ADDR_W +: TAG_W];
   assign out_tex   = c2i_head[TEX_B];

endmodule

// File: rtl/mpart_router_chk.sv
module mpart_router_chk #(
   parameter int REQ_W = 41
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic [1:0]       lk_status,
   input logic             cdone_valid,
   input logic             cdone_ready,
   input logic             out_valid,
   input logic             dreq_valid,
   input logic             fill_valid,
   input logic             busy,
   input logic             part_full,
   input logic             i2c_push,
   input logic             c2d_full,
   input logic [REQ_W-1:0] i2c_head
);

   assert_lookup_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> (cdone_ready && !cdone_valid));

   assert_rsvfail_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_status[1]) |=> $stable(i2c_head));

   assert_head_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> !c2d_full);

   assert_full_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
      part_full |-> !i2c_push);

   assert_busy_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid || dreq_valid || fill_valid || lk_valid) |-> busy);

endmodule

bind mpart_router mpart_router_chk #(.REQ_W(REQ_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lk_valid    (lk_valid),
   .lk_status   (lk_status),
   .cdone_valid (cdone_valid),
   .cdone_ready (cdone_ready),
   .out_valid   (out_valid),
   .dreq_valid  (dreq_valid),
   .fill_valid  (fill_valid),
   .busy        (busy),
   .part_full   (part_full),
   .i2c_push    (i2c_push),
   .c2d_full    (c2d_full),
   .i2c_head    (i2c_head)
);

// File: tb/mpart_router_test.sv
`timescale 1ns/1ps
module mpart_router_test;
   localparam int AW = 16, TW = 8, DLYC = 6, DDLY = 4, DI2C = 2, DC2D = 3, DD2C = 2, DC2I = 4;
   localparam int MAXO = 10, TSW = 16;
   localparam int RW = AW + TW + 1;

   logic clk = 0, rst_n = 0;
   always #2 clk = ~clk;

   logic in_valid = 0, in_tex = 0, cdone_valid = 0, dreq_ready = 0, drsp_valid = 0, drsp_tex = 0, out_ready = 0;
   logic [AW-1:0] in_addr = '0, cdone_addr = '0, drsp_addr = '0;
   logic [TW-1:0] in_tag = '0, cdone_tag = '0, drsp_tag = '0;
   logic rsv_block = 0;
   logic in_ready, part_full, lk_valid, fill_valid, cdone_ready, dreq_valid, dreq_tex, drsp_ready, out_valid, out_tex, busy;
   logic [AW-1:0] lk_addr, fill_addr, dreq_addr, out_addr;
   logic [TW-1:0] lk_tag, fill_tag, dreq_tag, out_tag;
   logic [1:0] lk_status;

   assign lk_status = rsv_block ? 2'd2 : (lk_addr[0] ? 2'd1 : 2'd0);

   mpart_router #(.ADDR_W(AW), .TAG_W(TW), .DELAY(DLYC), .D_DLY(DDLY), .D_I2C(DI2C), .D_C2D(DC2D),
                  .D_D2C(DD2C), .D_C2I(DC2I), .MAX_OUT(MAXO), .TS_W(TSW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_tex(in_tex),
      .in_tag(in_tag), .part_full(part_full), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_tag(lk_tag),
      .lk_status(lk_status), .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_tag(fill_tag),
      .cdone_valid(cdone_valid), .cdone_ready(cdone_ready), .cdone_addr(cdone_addr), .cdone_tag(cdone_tag),
      .dreq_valid(dreq_valid), .dreq_ready(dreq_ready), .dreq_addr(dreq_addr), .dreq_tex(dreq_tex),
      .dreq_tag(dreq_tag), .drsp_valid(drsp_valid), .drsp_ready(drsp_ready), .drsp_addr(drsp_addr),
      .drsp_tex(drsp_tex), .drsp_tag(drsp_tag), .out_valid(out_valid), .out_ready(out_ready),
      .out_addr(out_addr), .out_tex(out_tex), .out_tag(out_tag), .busy(busy));

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit finished = 0;

   // reference model state
   logic [RW-1:0] m_dly[$], m_i2c[$], m_c2d[$], m_d2c[$], m_c2i[$];
   int m_ts[$];
   int m_now = 0, m_out = 0;
   // external agents
   logic [RW-1:0] dram_pend[$], cache_pend[$], inj[$];
   int p_in = 0, p_tex = 0, p_out = 0, p_dreq = 0, p_drsp = 0, p_cdone = 0, p_rsv = 0;
   logic [TW-1:0] tag_ctr = 8'd16;
   int r2_t = -1;
   bit r2_done = 0, seen_tag4 = 0;

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit roll(input int p);
      return $urandom_range(99) < p;
   endfunction

   task automatic step();
      logic [RW-1:0] d2c0, i2c0, c2d0, c2i0, r;
      bit e_in_ready, e_full, c2i_full, done_push, e_fill, fwd, go, htex, e_lk, hit, miss, acc, rel, opop, dpop, dpush;
      int st;
      // drive inputs
      if (inj.size() > 0) begin
         in_valid = 1; {in_tex, in_tag, in_addr} = inj[0];
      end else if (roll(p_in)) begin
         in_valid = 1; in_tex = roll(p_tex); in_tag = tag_ctr; in_addr = AW'($urandom);
      end else in_valid = 0;
      out_ready = roll(p_out); dreq_ready = roll(p_dreq); rsv_block = roll(p_rsv);
      drsp_valid = (dram_pend.size() > 0) && roll(p_drsp);
      r = drsp_valid ? dram_pend[0] : '0;
      {drsp_tex, drsp_tag, drsp_addr} = r;
      cdone_valid = (cache_pend.size() > 0) && roll(p_cdone);
      r = cdone_valid ? cache_pend[0] : '0;
      {cdone_tag, cdone_addr} = r[RW-2:0];
      #1;
      // expected values
      d2c0 = (m_d2c.size() > 0) ? m_d2c[0] : '0;
      i2c0 = (m_i2c.size() > 0) ? m_i2c[0] : '0;
      c2d0 = (m_c2d.size() > 0) ? m_c2d[0] : '0;
      c2i0 = (m_c2i.size() > 0) ? m_c2i[0] : '0;
      e_in_ready = (m_dly.size() < DDLY) && (m_out < MAXO);
      e_full = m_i2c.size() == DI2C;
      c2i_full = m_c2i.size() == DC2I;
      done_push = cdone_valid && !c2i_full;
      e_fill = (m_d2c.size() > 0) && d2c0[RW-1];
      fwd = (m_d2c.size() > 0) && !d2c0[RW-1] && !c2i_full && !done_push;
      go = (m_i2c.size() > 0) && (m_c2d.size() < DC2D);
      htex = i2c0[RW-1];
      e_lk = go && htex && !c2i_full && !done_push && !fwd;
      st = rsv_block ? 2 : (i2c0[0] ? 1 : 0);
      hit = e_lk && st == 0; miss = e_lk && st == 1;
      chk("R1", "in_ready", 64'(in_ready), 64'(e_in_ready));
      chk("R3", "part_full", 64'(part_full), 64'(e_full));
      chk("R4", "cdone_ready", 64'(cdone_ready), 64'(!c2i_full));
      chk("R5", "fill_valid", 64'(fill_valid), 64'(e_fill));
      if (e_fill) chk("R5", "fill fields", 64'({fill_tag, fill_addr}), 64'(d2c0[RW-2:0]));
      chk("R7", "lk_valid", 64'(lk_valid), 64'(e_lk));
      if (e_lk) chk("R7", "lk fields", 64'({lk_tag, lk_addr}), 64'(i2c0[RW-2:0]));
      chk("R9", "dreq_valid", 64'(dreq_valid), 64'(m_c2d.size() > 0));
      if (m_c2d.size() > 0) chk("R8", "dreq fields", 64'({dreq_tex, dreq_tag, dreq_addr}), 64'(c2d0));
      chk("R9", "drsp_ready", 64'(drsp_ready), 64'(m_d2c.size() < DD2C));
      chk("R11", "out_valid", 64'(out_valid), 64'(m_c2i.size() > 0));
      if (m_c2i.size() > 0) chk("R11", "out fields", 64'({out_tex, out_tag, out_addr}), 64'(c2i0));
      chk("R10", "busy", 64'(busy), 64'(m_out != 0));
      if (r2_t >= 0 && !r2_done && dreq_valid && dreq_tag == 8'hA5) begin
         chk("R2", "ingress latency", 64'(cyc - r2_t), 64'(DLYC + 2));
         r2_done = 1;
      end
      // transfers
      acc  = in_valid && e_in_ready;
      rel  = (m_dly.size() > 0) && (m_now - m_ts[0] >= DLYC) && !e_full;
      opop = (m_c2i.size() > 0) && out_ready;
      dpop = (m_c2d.size() > 0) && dreq_ready;
      dpush = drsp_valid && (m_d2c.size() < DD2C);
      if (opop) begin
         if (c2i0[RW-2 -: TW] == 8'd4) seen_tag4 = 1;
         void'(m_c2i.pop_front());
      end
      if (done_push) m_c2i.push_back({1'b1, cdone_tag, cdone_addr});
      else if (fwd)  m_c2i.push_back(d2c0);
      else if (hit)  m_c2i.push_back(i2c0);
      if (e_fill || fwd) void'(m_d2c.pop_front());
      if (e_fill) cache_pend.push_back(d2c0);
      if (dpush) begin m_d2c.push_back({drsp_tex, drsp_tag, drsp_addr}); void'(dram_pend.pop_front()); end
      if (done_push) void'(cache_pend.pop_front());
      if (dpop) begin void'(m_c2d.pop_front()); dram_pend.push_back(c2d0); end
      if (miss) dram_pend.push_back(i2c0);
      if (go && !htex) m_c2d.push_back(i2c0);
      if ((go && !htex) || hit || miss) void'(m_i2c.pop_front());
      if (rel) begin m_i2c.push_back(m_dly[0]); void'(m_dly.pop_front()); void'(m_ts.pop_front()); end
      if (acc) begin
         m_dly.push_back({in_tex, in_tag, in_addr}); m_ts.push_back(m_now);
         if (in_tag == 8'hA5 && r2_t < 0) r2_t = cyc;
         if (inj.size() > 0) void'(inj.pop_front()); else tag_ctr = tag_ctr + 1'b1;
         if (tag_ctr == 8'hA5) tag_ctr = 8'd16;
      end
      m_out = m_out + (acc ? 1 : 0) - (opop ? 1 : 0);
      m_now++; cyc++;
      @(negedge clk);
   endtask

   task automatic knobs(input int pi, input int pt, input int po, input int pq, input int pr, input int pc, input int pv);
      p_in = pi; p_tex = pt; p_out = po; p_dreq = pq; p_drsp = pr; p_cdone = pc; p_rsv = pv;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1;
      // R12: reset state
      #1;
      chk("R12", "in_ready after reset", 64'(in_ready), 64'd1);
      chk("R12", "busy after reset", 64'(busy), 64'd0);
      chk("R12", "out_valid after reset", 64'(out_valid), 64'd0);
      chk("R12", "dreq_valid after reset", 64'(dreq_valid), 64'd0);
      chk("R12", "part_full after reset", 64'(part_full), 64'd0);
      @(negedge clk);
      // R2: single non-texture request on an idle path
      knobs(0, 0, 100, 0, 0, 0, 0);
      inj.push_back({1'b0, 8'hA5, 16'h1234});
      repeat (DLYC + 6) step();
      chk("R2", "latency measured", 64'(r2_done), 64'd1);
      knobs(0, 0, 100, 100, 100, 100, 0);
      repeat (10) step();
      // R6: DRAM request queue full holds the texture head
      knobs(0, 0, 100, 0, 0, 0, 0);
      for (int i = 1; i <= DC2D; i++) inj.push_back({1'b0, 8'(i), 16'(i * 2)});
      inj.push_back({1'b1, 8'd4, 16'h0040});
      repeat (40) step();
      chk("R6", "lookup held while DRAM queue full", 64'(lk_valid), 64'd0);
      knobs(0, 0, 100, 100, 100, 100, 0);
      repeat (30) step();
      chk("R7", "texture hit delivered", 64'(seen_tag4), 64'd1);
      // random phases
      knobs(50, 50, 80, 70, 60, 60, 20);  repeat (800) step();
      knobs(90, 50, 10, 20, 60, 60, 20);  repeat (800) step();
      knobs(70, 100, 70, 70, 70, 50, 50); repeat (800) step();
      knobs(70, 0, 60, 60, 100, 60, 0);   repeat (800) step();
      knobs(100, 50, 100, 100, 100, 100, 30); repeat (800) step();
      // drain
      knobs(0, 50, 100, 100, 100, 100, 0);
      for (int i = 0; i < 2000 && (m_out != 0 || m_dly.size() != 0); i++) step();
      repeat (3) step();
      chk("R10", "busy after drain", 64'(busy), 64'd0);
      chk("R10", "model drained", 64'(m_out), 64'd0);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule